// File: doc/BRIEF.md
# Ring-Addressed Dual-Edge Delay Buffer

This block is a fixed-length delay line for a sample stream. Every sample accepted on the input comes back out on the output exactly N accepted samples later. Storage is a small bank of N words, and the words are always visited in order. There is no binary address and no decoder. A single token circulates around a ring of N bits, and the bit that holds the token enables its own word directly. In each sample slot the selected word is presented on the output, and the new input sample then overwrites it.

A slot ends on every clock edge, rising or falling, so the clock runs at half the sample rate. The ring is cut into groups of G words. A group's token bits and its data drivers only switch while the token is in that group or about to arrive. Write data travels to the words through a tree of gated drivers. Read data is collected through a matching tree, so an idle subtree sees no transitions.

The stream interface is valid/ready and passes straight through. A slot fires at a clock edge when `in_valid` and `out_ready` are both high at that edge. `in_ready` mirrors `out_ready` and `out_valid` mirrors `in_valid` combinationally. A consumer that stalls therefore stalls the producer in the same slot. During a stall the token and all stored words keep their values.

Top module: `dly_ring_buf`

## Requirements
- R1: A sample accepted in slot s appears on `out_data` during accepted slot s+N, where only slots with `in_valid && out_ready` at the edge are counted.
- R2: Slots fire at both clock edges, so two samples can be accepted per clock period, one at the rising edge and one at the falling edge.
- R3: At an edge where `in_valid && out_ready` is low, the token position and all words keep their values. `out_data` keeps showing the word of the current slot.
- R4: `in_ready` always equals `out_ready`, and `out_valid` always equals `in_valid`.
- R5: A synchronous `rst`, sampled at both edges and held for at least one full period, puts the token at slot 0 and clears every word. After release `out_data` is zero, and the first N accepted outputs are zero.
- R6: `grp_act` has exactly one bit set. Bit g is set exactly when the token is at a slot in the range g*G to g*G+G-1.
- R7: After slot N-1 the token wraps to slot 0, and `grp_act` returns from bit N/G-1 to bit 0.
- R8: Within one slot `out_data` is the old content of the selected word and does not show the `in_data` being written in that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. Both edges end a sample slot |
| rst | input | 1 | Synchronous reset, active high, sampled at both edges |
| in_valid | input | 1 | Input sample present |
| in_ready | output | 1 | Input may be accepted (equals `out_ready`) |
| in_data | input | W | Input sample |
| out_valid | output | 1 | Output sample present (equals `in_valid`) |
| out_ready | input | 1 | Consumer accepts the output sample |
| out_data | output | W | Delayed sample, the old content of the current word |
| grp_act | output | N/G | One-hot group that holds the token |

## Verification
In an accepted slot, the read of a word's old content and the write of the new sample into that same word happen together. The bench drives a counting sequence so that the input and the expected output always differ, and it checks that the output still shows the stored value and not the incoming one. A second coincidence is a group hand-off landing on a falling edge, including the wrap from the last group to the first. Odd slot counts and random stalls move these crossings onto both edge types. Each of them is judged against the group number the bench computes from its own slot counter.

// File: rtl/dly_ring_pkg.sv
package dly_ring_pkg;

  // number of levels below the root of a binary driver tree over n leaves
  function automatic int unsigned tree_depth(input int unsigned n);
    return (n <= 1) ? 0 : $clog2(n);
  endfunction

endpackage

// File: rtl/dly_ring_ptr.sv
module dly_ring_ptr #(
  parameter int unsigned N = 16,
  parameter int unsigned G = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  output logic [N-1:0]     bank_rise,
  output logic [N-1:0]     bank_fall,
  output logic [N-1:0]     tok,
  output logic [N/G-1:0]   grp_act,
  output logic [N/G-1:0]   grp_live
);
  localparam int unsigned NG = N / G;

  logic [N-1:0] step_rise;
  logic [N-1:0] step_fall;

  // the rising bank takes over from what the falling bank showed, and vice versa
  assign step_rise = adv ? {bank_fall[N-2:0], bank_fall[N-1]} : bank_fall;
  assign step_fall = adv ? {bank_rise[N-2:0], bank_rise[N-1]} : bank_rise;

  // level-selected view of the dual-edge ring
  assign tok = clk ? bank_rise : bank_fall;

  for (genvar g = 0; g < NG; g++) begin : grp
    localparam int unsigned LO  = g * G;
    localparam int unsigned PRV = (g == 0) ? N - 1 : LO - 1;
    localparam logic [G-1:0] INIT = (g == 0) ? G'(1) : '0;

    logic [G-1:0] seg_r;
    logic [G-1:0] seg_f;
    logic         clk_en;

    // enable rises when the token is inside or next door, and drops only
    // once both banks agree the group is empty
    assign clk_en = (|seg_r) | (|seg_f) | bank_rise[PRV] | bank_fall[PRV];

    always_ff @(posedge clk) begin
      if (rst)         seg_r <= INIT;
      else if (clk_en) seg_r <= step_rise[LO +: G];
    end

    always_ff @(negedge clk) begin
      if (rst)         seg_f <= INIT;
      else if (clk_en) seg_f <= step_fall[LO +: G];
    end

    assign bank_rise[LO +: G] = seg_r;
    assign bank_fall[LO +: G] = seg_f;
    assign grp_act[g]  = |tok[LO +: G];
    assign grp_live[g] = (|seg_r) | (|seg_f);
  end

endmodule

// File: rtl/dly_word.sv
module dly_word #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         we_rise,
  input  logic         we_fall,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] half_r;
  logic [W-1:0] half_f;

  // the stored value is the XOR of two half-registers, so either edge can write it
  always_ff @(posedge clk) begin
    if (rst)          half_r <= '0;
    else if (we_rise) half_r <= d ^ half_f;
  end

  always_ff @(negedge clk) begin
    if (rst)          half_f <= '0;
    else if (we_fall) half_f <= d ^ half_r;
  end

  assign q = half_r ^ half_f;

endmodule

// File: rtl/dly_gate_tree.sv
module dly_gate_tree #(
  parameter int unsigned NG = 4,
  parameter int unsigned W  = 8
) (
  input  logic [NG-1:0]         live,
  input  logic [NG-1:0]         rd_sel,
  input  logic [W-1:0]          root_wd,
  input  logic [NG-1:0][W-1:0]  leaf_rd,
  output logic [NG-1:0][W-1:0]  leaf_wd,
  output logic [W-1:0]          root_rd
);
  import dly_ring_pkg::*;

  localparam int unsigned LV  = tree_depth(NG);
  localparam int unsigned NGP = 1 << LV;

  for (genvar l = 0; l <= LV; l++) begin : lv
    localparam int unsigned NN = 1 << l;
    logic [NN-1:0] en;
    logic [W-1:0]  wd [NN];
    logic [W-1:0]  rd [NN];

    for (genvar j = 0; j < NN; j++) begin : nd
      if (l == LV) begin : leaf
        if (j < NG) begin : real_leaf
          assign en[j] = live[j];
          assign rd[j] = rd_sel[j] ? leaf_rd[j] : '0;
        end else begin : pad_leaf
          assign en[j] = 1'b0;
          assign rd[j] = '0;
        end
      end else begin : inner
        assign en[j] = lv[l+1].en[2*j] | lv[l+1].en[2*j+1];
        assign rd[j] = lv[l+1].rd[2*j] | lv[l+1].rd[2*j+1];
      end

      if (l == 0) begin : top_drv
        assign wd[j] = en[j] ? root_wd : '0;
      end else begin : sub_drv
        assign wd[j] = en[j] ? lv[l-1].wd[j/2] : '0;
      end
    end
  end

  for (genvar g = 0; g < NG; g++) begin : out_leaf
    assign leaf_wd[g] = lv[LV].wd[g];
  end

  assign root_rd = lv[0].rd[0];

endmodule

// File: rtl/dly_ring_buf.sv
module dly_ring_buf #(
  parameter int unsigned N = 16,
  parameter int unsigned G = 4,
  parameter int unsigned W = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [W-1:0]   in_data,
  output logic           out_valid,
  input  logic           out_ready,
  output logic [W-1:0]   out_data,
  output logic [N/G-1:0] grp_act
);
  localparam int unsigned NG = N / G;

  logic                 fire;
  logic [N-1:0]         bank_rise;
  logic [N-1:0]         bank_fall;
  logic [N-1:0]         tok;
  logic [NG-1:0]        grp_live;
  logic [NG-1:0][W-1:0] leaf_wd;
  logic [NG-1:0][W-1:0] leaf_rd;
  logic [W-1:0]         word_q [N];

  assign fire      = in_valid & out_ready;
  assign in_ready  = out_ready;
  assign out_valid = in_valid;

  dly_ring_ptr #(.N(N), .G(G)) u_ptr (
    .clk       (clk),
    .rst       (rst),
    .adv       (fire),
    .bank_rise (bank_rise),
    .bank_fall (bank_fall),
    .tok       (tok),
    .grp_act   (grp_act),
    .grp_live  (grp_live)
  );

  for (genvar k = 0; k < N; k++) begin : wrd
    // a rising edge closes the slot shown by the falling bank, and vice versa
    dly_word #(.W(W)) u_word (
      .clk     (clk),
      .rst     (rst),
      .we_rise (fire & bank_fall[k]),
      .we_fall (fire & bank_rise[k]),
      .d       (leaf_wd[k/G]),
      .q       (word_q[k])
    );
  end

  for (genvar g = 0; g < NG; g++) begin : gsel
    logic [W-1:0] part [G+1];
    assign part[0] = '0;
    for (genvar m = 0; m < G; m++) begin : ao
      assign part[m+1] = part[m] | (tok[g*G+m] ? word_q[g*G+m] : '0);
    end
    assign leaf_rd[g] = part[G];
  end

  dly_gate_tree #(.NG(NG), .W(W)) u_tree (
    .live    (grp_live),
    .rd_sel  (grp_act),
    .root_wd (fire ? in_data : '0),
    .leaf_rd (leaf_rd),
    .leaf_wd (leaf_wd),
    .root_rd (out_data)
  );

endmodule

// File: rtl/dly_ring_chk.sv
module dly_ring_chk #(
  parameter int unsigned N = 16,
  parameter int unsigned G = 4,
  parameter int unsigned W = 8
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic           in_ready,
  input logic [W-1:0]   in_data,
  input logic           out_valid,
  input logic           out_ready,
  input logic [W-1:0]   out_data,
  input logic [N/G-1:0] grp_act
);
  p_ready_mirror_r4: assert property (@(posedge clk) disable iff (rst)
    in_ready == out_ready);

  p_valid_mirror_r4: assert property (@(negedge clk) disable iff (rst)
    out_valid == in_valid);

  p_grp_onehot_rise_r6: assert property (@(posedge clk) disable iff (rst)
    $countones(grp_act) == 1);

  p_grp_onehot_fall_r6: assert property (@(negedge clk) disable iff (rst)
    $countones(grp_act) == 1);

  p_reset_clean_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_data == '0 && grp_act[0]));
endmodule

bind dly_ring_buf dly_ring_chk #(.N(N), .G(G), .W(W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .grp_act   (grp_act)
);

// File: tb/dly_ring_buf_bench.sv
module dly_ring_buf_bench;
  localparam int unsigned N  = 16;
  localparam int unsigned G  = 4;
  localparam int unsigned W  = 8;
  localparam int unsigned NG = N / G;
  localparam int CLK_PERIOD  = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic          out_ready = 1'b0;
  logic [W-1:0]  in_data = '0;
  logic          in_ready;
  logic          out_valid;
  logic [W-1:0]  out_data;
  logic [NG-1:0] grp_act;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic [W-1:0] hist [N];
  int ptr;
  int since_rst;
  bit wrapped;

  always #(CLK_PERIOD/2) clk = ~clk;

  dly_ring_buf #(.N(N), .G(G), .W(W)) u_dly_ring_buf (
    .clk(clk), .rst(rst),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .grp_act(grp_act)
  );

  function automatic logic [NG-1:0] exp_grp(input int p);
    return NG'(1) << (p / G);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) hist[i] = '0;
    ptr = 0; since_rst = 0; wrapped = 0;
  endtask

  task automatic do_reset();
    @(posedge clk); #1;
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    rst = 1'b0;
    model_clear();
    #3;
    check(out_data == '0, "R5", out_data, 0);
    check(grp_act == NG'(1), "R5", grp_act, 1);
  endtask

  // one slot: inputs act at the edge after this one
  task automatic slot(input bit v, input bit r, input logic [W-1:0] d);
    logic [W-1:0] e;
    bit rose;
    string lbl;
    @(posedge clk or negedge clk);
    rose = clk;
    #1;
    in_valid = v; out_ready = r; in_data = d;
    #3;
    e = hist[ptr];
    if (!(v && r))            lbl = "R3";
    else if (since_rst < N)   lbl = "R5";
    else if (rose)            lbl = "R2";
    else                      lbl = "R1";
    check(out_data == e, lbl, out_data, e);
    if (v && r && d != e) check(out_data != d, "R8", out_data, e);
    check(in_ready == r, "R4", in_ready, r);
    check(out_valid == v, "R4", out_valid, v);
    check(grp_act == exp_grp(ptr), (wrapped && ptr < G) ? "R7" : "R6",
          grp_act, exp_grp(ptr));
    if (v && r) begin
      hist[ptr] = d;
      ptr = (ptr + 1) % N;
      if (ptr == 0) wrapped = 1;
      since_rst++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1d0e_5eed));
    model_clear();
    do_reset();

    // counting stream, no stalls, several wraps on both edge types
    for (int i = 0; i < 3 * N + 1; i++) slot(1'b1, 1'b1, W'(i + 1));

    // stall directly on a group boundary, then hold it a few slots
    while (ptr % G != 0) slot(1'b1, 1'b1, W'($urandom));
    repeat (3) slot(1'b1, 1'b0, W'($urandom));
    repeat (2) slot(1'b0, 1'b1, W'($urandom));

    // random valid/ready mix
    for (int i = 0; i < 400; i++)
      slot(($urandom % 4) != 0, ($urandom % 3) != 0, W'($urandom));

    // mid-run reset, then the first N outputs must be zero
    do_reset();
    for (int i = 0; i < 2 * N + 3; i++) slot(1'b1, 1'b1, W'(8'h80 + i));

    in_valid = 1'b0;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule